// File: doc/BRIEF.md
# Branch and Jump Redirect Unit

This unit sits beside the execute stage of a pipelined core with one branch delay slot. For each control instruction it decides whether to redirect fetch, what the destination address is, and whether the link register is written. It also raises the alignment and illegal-instruction exception requests. A taken branch or jump does not redirect at once. The unit holds the destination until the next valid instruction, which is the delay slot, has been accepted, and only then does it pulse the redirect. Return-from-exception is the one control operation that redirects without a delay slot. It also hands back the saved status word so that the status register can be restored.

The unit accepts one instruction strobe per cycle and has no back-pressure: `in_valid` is never refused, and every result is a one-cycle pulse that the consumer must take in the cycle it appears. Cycles with `in_valid` low are bubbles. They do not count as the delay slot. A control instruction that arrives in the delay slot is a protocol violation. The unit flags it and drops its own control effect, while the pending redirect still completes.

Top module: `bju_top`

## Requirements
- R1: Operation code 1 (branch-if-flag) is taken when `flag` is 1, and code 2 (branch-if-clear) is taken when `flag` is 0. A branch that is not taken leaves `delay_pending` and `redir_valid` low.
- R2: For a taken branch (codes 1 and 2), a jump (code 3) or a jump-and-link (code 4), the destination is `pc + offset*4`, computed modulo 2^32.
- R3: `delay_pending` rises one cycle after the control strobe is accepted. `redir_valid` then pulses with the stored destination one cycle after the next strobe that has `in_valid` high, and `delay_pending` falls in that same cycle. Idle cycles keep the redirect pending.
- R4: Jump-and-link (code 4) and register jump-and-link (code 6) pulse `link_we` one cycle after the strobe, with `link_data = pc + 8`. No other operation writes the link register.
- R5: Register jump (code 5) and register jump-and-link (code 6) with `tgt_val[1:0] == 0` use `tgt_val` as the delayed destination.
- R6: A register jump (codes 5 and 6) with `tgt_val[1:0] != 0` pulses `exc_align` one cycle later. It gives no link write and no pending redirect.
- R7: Register jump-and-link (code 6) with `tgt_idx == 9` pulses `exc_illegal` rather than `exc_align`, even if the target is also misaligned. It gives no redirect and no link write. Register jump (code 5) does not make this check.
- R8: Return-from-exception (code 7) pulses `redir_valid` to `epcr`, `sr_restore_we` and `sr_restore_val = esr`, all one cycle after the strobe, with no delay slot.
- R9: A strobe with a nonzero code (codes 1 to 7) while `delay_pending` is high pulses `proto_err` one cycle later. That instruction has no control effect: it gives no link write, no exception and no status restore, and the pending redirect goes to its original destination. Code 0 is an ordinary instruction.
- R10: While reset is held, and after it is released, every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Instruction strobe |
| op | input | 3 | Control operation code (0 none, 1..7 as in the requirements) |
| pc | input | 32 | Address of the strobed instruction |
| offset | input | 32 | Sign-extended word offset |
| tgt_val | input | 32 | Register jump destination value |
| tgt_idx | input | 5 | Register index holding the destination |
| flag | input | 1 | Compare flag |
| epcr | input | 32 | Saved exception PC |
| esr | input | 32 | Saved status word |
| redir_valid | output | 1 | Fetch redirect pulse |
| redir_target | output | 32 | Redirect address (0 when no pulse) |
| delay_pending | output | 1 | A delayed redirect waits for its slot |
| link_we | output | 1 | Link register write pulse |
| link_data | output | 32 | Link value (0 when no write) |
| sr_restore_we | output | 1 | Status restore pulse |
| sr_restore_val | output | 32 | Status value to restore (0 when no pulse) |
| exc_align | output | 1 | Misaligned register jump |
| exc_illegal | output | 1 | Register jump-and-link through the link register |
| proto_err | output | 1 | Control instruction in the delay slot |

## Verification
Every result is due exactly one clock edge after the strobe that causes it. The delayed redirect is the exception: it appears one edge after the delay-slot strobe, however many idle cycles come in between. The bench drives inputs on the falling edge and advances its reference model once per cycle. It compares every output on the following falling edge, so each comparison lines up with the single register stage. Sequences with bubbles inside the delay slot, and with control instructions placed in the slot, check that the pending state is held and released at the right time.

// File: rtl/bju_pkg.sv
package bju_pkg;
  typedef enum logic [2:0] {
    BJ_NONE = 3'd0,
    BJ_BF   = 3'd1,
    BJ_BNF  = 3'd2,
    BJ_J    = 3'd3,
    BJ_JAL  = 3'd4,
    BJ_JR   = 3'd5,
    BJ_JALR = 3'd6,
    BJ_RFE  = 3'd7
  } bj_op_e;

  typedef struct packed {
    logic go;        // arm a delayed redirect
    logic link;      // write the link register
    logic use_reg;   // destination comes from the register value
    logic misalign;  // alignment exception
    logic illegal;   // illegal-instruction exception
    logic rfe;       // immediate return-from-exception
  } bj_dec_t;
endpackage

// File: rtl/bju_decode.sv
module bju_decode
  import bju_pkg::*;
#(
  parameter int RIDX_W   = 5,
  parameter int LINK_IDX = 9,
  parameter int LOW_W    = 2,
  parameter bit CHK_LOW  = 1'b1
) (
  input  bj_op_e              op,
  input  logic                flag,
  input  logic [RIDX_W-1:0]   tgt_idx,
  input  logic [LOW_W-1:0]    tgt_low,
  output bj_dec_t             dec
);
  logic mis;
  logic via_link;

  generate
    if (CHK_LOW) begin : g_chk
      assign mis = |tgt_low;
    end else begin : g_nochk
      assign mis = 1'b0;
    end
  endgenerate

  assign via_link = (tgt_idx == RIDX_W'(LINK_IDX));

  always_comb begin
    dec = '0;
    unique case (op)
      BJ_BF:   dec.go = flag;
      BJ_BNF:  dec.go = ~flag;
      BJ_J:    dec.go = 1'b1;
      BJ_JAL: begin
        dec.go   = 1'b1;
        dec.link = 1'b1;
      end
      BJ_JR: begin
        dec.use_reg  = 1'b1;
        dec.misalign = mis;
        dec.go       = ~mis;
      end
      BJ_JALR: begin
        dec.use_reg = 1'b1;
        if (via_link) begin
          dec.illegal = 1'b1;
        end else if (mis) begin
          dec.misalign = 1'b1;
        end else begin
          dec.go   = 1'b1;
          dec.link = 1'b1;
        end
      end
      BJ_RFE:  dec.rfe = 1'b1;
      default: dec = '0;
    endcase
  end
endmodule

// File: rtl/bju_target.sv
module bju_target #(
  parameter int AW        = 32,
  parameter int SH        = 2,
  parameter int LINK_STEP = 8
) (
  input  logic [AW-1:0] pc,
  input  logic [AW-1:0] offset,
  input  logic [AW-1:0] tgt_val,
  input  logic          use_reg,
  output logic [AW-1:0] jump_tgt,
  output logic [AW-1:0] link_val
);
  logic [AW-1:0] rel_tgt;

  assign rel_tgt  = pc + (offset << SH);
  assign jump_tgt = use_reg ? tgt_val : rel_tgt;
  assign link_val = pc + AW'(LINK_STEP);
endmodule

// File: rtl/bju_seq.sv
module bju_seq #(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          slot_seen,
  input  logic          arm,
  input  logic [AW-1:0] arm_tgt,
  input  logic          now,
  input  logic [AW-1:0] now_tgt,
  output logic          pending,
  output logic          redir_valid,
  output logic [AW-1:0] redir_target
);
  logic [AW-1:0] held_tgt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pending      <= 1'b0;
      held_tgt     <= '0;
      redir_valid  <= 1'b0;
      redir_target <= '0;
    end else begin
      redir_valid  <= 1'b0;
      redir_target <= '0;
      if (pending && slot_seen) begin
        pending      <= 1'b0;
        redir_valid  <= 1'b1;
        redir_target <= held_tgt;
      end else if (arm) begin
        pending  <= 1'b1;
        held_tgt <= arm_tgt;
      end else if (now) begin
        redir_valid  <= 1'b1;
        redir_target <= now_tgt;
      end
    end
  end
endmodule

// File: rtl/bju_top.sv
module bju_top
  import bju_pkg::*;
#(
  parameter int AW          = 32,
  parameter int SRW         = 32,
  parameter int RIDX_W      = 5,
  parameter int LINK_IDX    = 9,
  parameter int INSN_BYTES  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [2:0]        op,
  input  logic [AW-1:0]     pc,
  input  logic [AW-1:0]     offset,
  input  logic [AW-1:0]     tgt_val,
  input  logic [RIDX_W-1:0] tgt_idx,
  input  logic              flag,
  input  logic [AW-1:0]     epcr,
  input  logic [SRW-1:0]    esr,
  output logic              redir_valid,
  output logic [AW-1:0]     redir_target,
  output logic              delay_pending,
  output logic              link_we,
  output logic [AW-1:0]     link_data,
  output logic              sr_restore_we,
  output logic [SRW-1:0]    sr_restore_val,
  output logic              exc_align,
  output logic              exc_illegal,
  output logic              proto_err
);
  localparam int  SH        = $clog2(INSN_BYTES);
  localparam int  LOW_W     = (SH > 0) ? SH : 1;
  localparam bit  CHK_LOW   = (SH > 0);
  localparam int  LINK_STEP = 2 * INSN_BYTES;

  bj_dec_t       dec;
  logic          act;
  logic          pending;
  logic [AW-1:0] jump_tgt;
  logic [AW-1:0] link_val;

  assign act = in_valid & ~pending;

  bju_decode #(
    .RIDX_W(RIDX_W), .LINK_IDX(LINK_IDX), .LOW_W(LOW_W), .CHK_LOW(CHK_LOW)
  ) u_dec (
    .op(bj_op_e'(op)), .flag(flag), .tgt_idx(tgt_idx),
    .tgt_low(tgt_val[LOW_W-1:0]), .dec(dec)
  );

  bju_target #(.AW(AW), .SH(SH), .LINK_STEP(LINK_STEP)) u_tgt (
    .pc(pc), .offset(offset), .tgt_val(tgt_val), .use_reg(dec.use_reg),
    .jump_tgt(jump_tgt), .link_val(link_val)
  );

  bju_seq #(.AW(AW)) u_seq (
    .clk(clk), .rst_n(rst_n), .slot_seen(in_valid),
    .arm(act & dec.go), .arm_tgt(jump_tgt),
    .now(act & dec.rfe), .now_tgt(epcr),
    .pending(pending), .redir_valid(redir_valid), .redir_target(redir_target)
  );

  assign delay_pending = pending;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      link_we        <= 1'b0;
      link_data      <= '0;
      sr_restore_we  <= 1'b0;
      sr_restore_val <= '0;
      exc_align      <= 1'b0;
      exc_illegal    <= 1'b0;
      proto_err      <= 1'b0;
    end else begin
      link_we        <= act & dec.link;
      link_data      <= (act & dec.link) ? link_val : '0;
      sr_restore_we  <= act & dec.rfe;
      sr_restore_val <= (act & dec.rfe) ? esr : '0;
      exc_align      <= act & dec.misalign;
      exc_illegal    <= act & dec.illegal;
      proto_err      <= in_valid & pending & (op != 3'd0);
    end
  end
endmodule

// File: rtl/bju_chk.sv
module bju_chk #(
  parameter int AW         = 32,
  parameter int SRW        = 32,
  parameter int INSN_BYTES = 4
) (
  input logic           clk,
  input logic           rst_n,
  input logic           in_valid,
  input logic [2:0]     op,
  input logic [AW-1:0]  pc,
  input logic           flag,
  input logic [AW-1:0]  epcr,
  input logic [SRW-1:0] esr,
  input logic           redir_valid,
  input logic [AW-1:0]  redir_target,
  input logic           delay_pending,
  input logic           link_we,
  input logic [AW-1:0]  link_data,
  input logic           sr_restore_we,
  input logic [SRW-1:0] sr_restore_val,
  input logic           exc_align,
  input logic           exc_illegal,
  input logic           proto_err
);
  localparam int STEP = 2 * INSN_BYTES;

  // R1
  bf_not_taken_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !delay_pending && op == 3'd1 && !flag) |=> (!delay_pending && !redir_valid));

  // R3
  redir_after_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (redir_valid && !sr_restore_we) |-> ($past(delay_pending) && $past(in_valid)));

  // R3
  pend_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (delay_pending && !in_valid) |=> delay_pending);

  // R4
  link_val_chk: assert property (@(posedge clk) disable iff (!rst_n)
    link_we |-> (link_data == $past(pc) + AW'(STEP)));

  // R6
  exc_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (exc_align || exc_illegal) |-> (!link_we && !delay_pending));

  // R7
  exc_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({exc_align, exc_illegal}));

  // R8
  rfe_restore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sr_restore_we |-> (redir_valid && redir_target == $past(epcr) && sr_restore_val == $past(esr)));

  // R9
  proto_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    proto_err |-> ($past(delay_pending) && redir_valid && !link_we && !sr_restore_we));
endmodule

bind bju_top bju_chk #(.AW(AW), .SRW(SRW), .INSN_BYTES(INSN_BYTES)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op(op), .pc(pc), .flag(flag),
  .epcr(epcr), .esr(esr), .redir_valid(redir_valid), .redir_target(redir_target),
  .delay_pending(delay_pending), .link_we(link_we), .link_data(link_data),
  .sr_restore_we(sr_restore_we), .sr_restore_val(sr_restore_val),
  .exc_align(exc_align), .exc_illegal(exc_illegal), .proto_err(proto_err)
);

// File: tb/bju_top_tb.sv
module bju_top_tb;
  localparam int HALF = 10;
  localparam logic [2:0] C_NONE = 3'd0, C_BF = 3'd1, C_BNF = 3'd2, C_J = 3'd3,
                         C_JAL = 3'd4, C_JR = 3'd5, C_JALR = 3'd6, C_RFE = 3'd7;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic [2:0] op = '0;
  logic [31:0] pc = '0, offset = '0, tgt_val = '0, epcr = '0, esr = '0;
  logic [4:0] tgt_idx = '0;
  logic flag = 1'b0;
  logic redir_valid, delay_pending, link_we, sr_restore_we, exc_align, exc_illegal, proto_err;
  logic [31:0] redir_target, link_data, sr_restore_val;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  bit          m_pend = 1'b0;
  logic [31:0] m_tgt = '0;

  always #HALF clk = ~clk;

  bju_top u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op(op), .pc(pc), .offset(offset),
    .tgt_val(tgt_val), .tgt_idx(tgt_idx), .flag(flag), .epcr(epcr), .esr(esr),
    .redir_valid(redir_valid), .redir_target(redir_target), .delay_pending(delay_pending),
    .link_we(link_we), .link_data(link_data), .sr_restore_we(sr_restore_we),
    .sr_restore_val(sr_restore_val), .exc_align(exc_align), .exc_illegal(exc_illegal),
    .proto_err(proto_err)
  );

  task automatic compare(input string req, input logic [102:0] exp_v);
    logic [102:0] act_v;
    act_v = {redir_valid, redir_target, delay_pending, link_we, link_data,
             sr_restore_we, sr_restore_val, exc_align, exc_illegal, proto_err};
    checks++;
    if (act_v !== exp_v) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act_v, exp_v);
    end
  endtask

  // One instruction cycle: drive at the falling edge, model, compare at the next falling edge.
  task automatic step(input string req, input logic v, input logic [2:0] o,
                      input logic [31:0] p, input logic [31:0] off,
                      input logic [31:0] tv, input logic [4:0] ti, input logic f);
    logic e_rv, e_lw, e_sw, e_al, e_il, e_pe;
    logic [31:0] e_rt, e_ld, e_sv;
    e_rv = 0; e_lw = 0; e_sw = 0; e_al = 0; e_il = 0; e_pe = 0;
    e_rt = '0; e_ld = '0; e_sv = '0;
    in_valid = v; op = o; pc = p; offset = off; tgt_val = tv; tgt_idx = ti; flag = f;
    if (v) begin
      if (m_pend) begin
        e_rv = 1; e_rt = m_tgt; m_pend = 0;
        if (o != C_NONE) e_pe = 1;
      end else begin
        case (o)
          C_BF:  if (f)  begin m_pend = 1; m_tgt = p + off * 4; end
          C_BNF: if (!f) begin m_pend = 1; m_tgt = p + off * 4; end
          C_J:   begin m_pend = 1; m_tgt = p + off * 4; end
          C_JAL: begin m_pend = 1; m_tgt = p + off * 4; e_lw = 1; e_ld = p + 8; end
          C_JR, C_JALR: begin
            if (o == C_JALR && ti == 5'd9) e_il = 1;
            else if (tv % 4 != 0) e_al = 1;
            else begin
              m_pend = 1; m_tgt = tv;
              if (o == C_JALR) begin e_lw = 1; e_ld = p + 8; end
            end
          end
          C_RFE: begin e_rv = 1; e_rt = epcr; e_sw = 1; e_sv = esr; end
          default: ;
        endcase
      end
    end
    @(posedge clk);
    @(negedge clk);
    compare(req, {e_rv, e_rt, m_pend, e_lw, e_ld, e_sw, e_sv, e_al, e_il, e_pe});
  endtask

  task automatic idle(input string req);
    step(req, 1'b0, C_NONE, 32'h0, 32'h0, 32'h0, 5'd0, 1'b0);
  endtask

  initial begin
    repeat (HALF * 200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    compare("R10 in reset", '0);
    rst_n = 1'b1;
    @(negedge clk);
    compare("R10 after reset", '0);

    // R1 R2 R3: branch-if-flag taken, delay slot, redirect
    step("R1 bf taken", 1, C_BF, 32'h0000_1000, 32'h0000_0010, 0, 0, 1);
    step("R3 slot", 1, C_NONE, 32'h0000_1004, 0, 0, 0, 0);
    idle("R3 after redirect");
    // R1 not taken cases
    step("R1 bf not taken", 1, C_BF, 32'h0000_2000, 32'h0000_0004, 0, 0, 0);
    step("R1 bnf not taken", 1, C_BNF, 32'h0000_2004, 32'h0000_0004, 0, 0, 1);
    // R2 R3: bnf taken with negative offset and bubbles in the slot
    step("R2 bnf neg", 1, C_BNF, 32'h0000_3000, 32'hFFFF_FFFD, 0, 0, 0);
    idle("R3 bubble 1");
    idle("R3 bubble 2");
    step("R3 late slot", 1, C_NONE, 32'h0000_3004, 0, 0, 0, 0);
    // R2 wraparound jump and R4 jump-and-link
    step("R2 j wrap", 1, C_J, 32'h0000_0008, 32'hFFFF_FFF0, 0, 0, 0);
    step("R3 slot j", 1, C_NONE, 32'h0000_000C, 0, 0, 0, 0);
    step("R4 jal", 1, C_JAL, 32'h0000_4000, 32'h0000_0100, 0, 0, 0);
    step("R3 slot jal", 1, C_NONE, 32'h0000_4004, 0, 0, 0, 0);
    // R5 register jumps
    step("R5 jr", 1, C_JR, 32'h0000_5000, 0, 32'h0008_0000, 5'd9, 0);
    step("R5 slot jr", 1, C_NONE, 32'h0000_5004, 0, 0, 0, 0);
    step("R5 jalr", 1, C_JALR, 32'h0000_6000, 0, 32'h0009_0010, 5'd3, 0);
    step("R4 slot jalr", 1, C_NONE, 32'h0000_6004, 0, 0, 0, 0);
    // R6 misalignment
    step("R6 jr mis", 1, C_JR, 32'h0000_7000, 0, 32'h0000_0102, 5'd4, 0);
    step("R6 jalr mis", 1, C_JALR, 32'h0000_7004, 0, 32'h0000_0101, 5'd4, 0);
    step("R6 after", 1, C_NONE, 32'h0000_7008, 0, 0, 0, 0);
    // R7 link register as destination
    step("R7 jalr link", 1, C_JALR, 32'h0000_8000, 0, 32'h0000_0200, 5'd9, 0);
    step("R7 priority", 1, C_JALR, 32'h0000_8004, 0, 32'h0000_0203, 5'd9, 0);
    // R8 return from exception
    epcr = 32'h0000_A5A0; esr = 32'h0000_8001;
    step("R8 rfe", 1, C_RFE, 32'h0000_9000, 0, 0, 0, 0);
    idle("R8 after");
    // R9 control instructions in the delay slot
    step("R9 arm", 1, C_J, 32'h0000_B000, 32'h0000_0020, 0, 0, 0);
    step("R9 jal in slot", 1, C_JAL, 32'h0000_B004, 32'h0000_0040, 0, 0, 0);
    idle("R9 no rearm");
    step("R9 arm2", 1, C_BF, 32'h0000_C000, 32'h0000_0008, 0, 0, 1);
    step("R9 rfe in slot", 1, C_RFE, 32'h0000_C004, 0, 0, 0, 0);
    step("R9 arm3", 1, C_JR, 32'h0000_D000, 0, 32'h0000_0400, 5'd2, 0);
    step("R9 mis in slot", 1, C_JALR, 32'h0000_D004, 0, 32'h0000_0003, 5'd9, 0);
    idle("R9 quiet");

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule